// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave port. It lets an external host read and write an 8-bit-wide register space with 13-bit addresses. A transfer starts when the chip select goes low. The host then shifts in a 16-bit command word, followed by one or more data bytes. The command word carries the direction, a length code and a start address. During a multibyte transfer the address moves on by itself after each byte. It counts up in most-significant-first mode and down in least-significant-first mode.

The port owns four local registers:

- a control register, which selects the wire mode, selects the bit order and issues a soft reset;
- one spare register;
- two fixed identification registers.

Every other address goes to downstream logic through a simple strobe interface. The downstream logic answers a read in the same clock cycle as the strobe.

The serial pins are assumed to be already synchronous to `clk`. Edges of the serial clock are found by sampling it with `clk`. Read data can come back in either of two ways:

- in 3-wire mode, on the shared data line, with an output enable;
- in 4-wire mode, on a separate output pin.

Top module: `spi_regport`

## Requirements
- R1: The command word is I[15:0], with I[15]=1 for a read and 0 for a write, I[14:13] the length code and I[12:0] the start address. In most-significant-first mode I[15] is sent first. Input bits are sampled on rising serial-clock edges, and read bits are launched on falling edges.
- R2: Length code 0, 1 and 2 move exactly 1, 2 and 3 bytes. Any further clocks in that transfer neither write nor read anything. Length code 3 streams bytes until chip select rises.
- R3: After each byte the address steps by +1 in most-significant-first mode and by -1 in least-significant-first mode, modulo 8192. Stepping down from 0x0000 gives 0x1FFF.
- R4: In least-significant-first mode the command word is sent I[0] first, and every data byte is sent bit 0 first.
- R5: In 3-wire mode, read bits appear on `sdio_out`, and `sdio_oe` is high only during the data phase of a read. In 4-wire mode, read bits appear on `sdo_out`, `sdo_oe` is high whenever chip select is low, and `sdio_oe` stays low. With chip select high, both enables are low.
- R6: Control register 0x0000 has bit 7 = 4-wire mode and bit 6 = least-significant-first mode. Bit 4 always reads 1, and bits 3:0 always read 0, so it reads 0x10 after reset. A new mode takes effect from the next transfer.
- R7: Writing 1 to bit 5 of register 0x0000 returns the control register to 0x10 and gives one `clk`-wide pulse on `soft_rst_o`. Bit 5 always reads 0.
- R8: Register 0x0001 reads 0x00, 0x0002 reads 0xF6 and 0x0003 reads 0x48, and writes to them change nothing.
- R9: Addresses 0x0004 and above use the downstream interface. `rf_wr` pulses with the assembled byte after the eighth bit of a written byte. `rf_rd` pulses, and `rf_rdata` is taken in the same cycle, before the first bit of each read byte. Addresses 0x0000 to 0x0003 never raise a strobe.
- R10: If chip select rises part-way through a transfer, the transfer is abandoned, and a partly received byte is not written. The next transfer starts with a fresh command word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also used to sample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| sdio_in | input | 1 | Shared data line, input side |
| sdio_out | output | 1 | Shared data line, output side (3-wire reads) |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_out | output | 1 | Dedicated serial data output (4-wire mode) |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| rf_wr | output | 1 | Downstream write strobe |
| rf_rd | output | 1 | Downstream read strobe |
| rf_addr | output | 13 | Downstream register address |
| rf_wdata | output | 8 | Downstream write data |
| rf_rdata | input | 8 | Downstream read data, valid in the `rf_rd` cycle |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
The assertions assume that the serial clock, chip select and data input change only away from the `clk` edge. They also assume that each level of the serial clock lasts at least two `clk` cycles, so that each rising and falling edge is seen exactly once. Chip select is assumed to change only while the serial clock is low. The stimulus generates the serial clock with four `clk` cycles per half period, and changes data and chip select on the falling `clk` edge while the serial clock is low. The downstream model answers reads combinationally, as the interface requires.

// File: rtl/spi_rp_pkg.sv
`timescale 1ns/1ps
package spi_rp_pkg;
    localparam int ADDR_W  = 13;
    localparam int BYTE_W  = 8;
    localparam int LEN_W   = 2;
    localparam int INSTR_W = 1 + LEN_W + ADDR_W;
    localparam int BCNT_W  = $clog2(INSTR_W);
    localparam int LOCAL_N = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_HOLD} phase_e;
    typedef enum logic [LEN_W-1:0] {LEN_1 = 2'd0, LEN_2, LEN_3, LEN_STREAM} len_e;

    typedef struct packed {
        logic  rd;
        len_e  len;
        addr_t addr;
    } instr_t;

    typedef struct packed {
        logic wire4;
        logic lsb;
    } mode_t;

    function automatic addr_t addr_next(addr_t a, logic lsb);
        return lsb ? a - 1'b1 : a + 1'b1;
    endfunction

    function automatic logic is_local(addr_t a);
        return a < ADDR_W'(LOCAL_N);
    endfunction

    function automatic byte_t shift_byte(byte_t cur, logic d, logic lsb);
        return lsb ? {d, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], d};
    endfunction

    function automatic logic [INSTR_W-1:0] shift_word(logic [INSTR_W-1:0] cur, logic d, logic lsb);
        return lsb ? {d, cur[INSTR_W-1:1]} : {cur[INSTR_W-2:0], d};
    endfunction
endpackage

// File: rtl/spi_rp_edge.sv
`timescale 1ns/1ps
module spi_rp_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/spi_rp_ctrl.sv
`timescale 1ns/1ps
module spi_rp_ctrl
    import spi_rp_pkg::*;
#(
    parameter byte_t REV_ID = 8'hF6,
    parameter byte_t DEV_ID = 8'h48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] sel,
    input  logic [2:0] wr_bits,   // data bits 7,6,5
    output byte_t      rd_data,
    output mode_t      mode,
    output logic       soft_rst
);
    mode_t mode_q;
    logic  srst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            srst_q <= 1'b0;
        end else begin
            srst_q <= 1'b0;
            if (wr_en && sel == 2'd0) begin
                if (wr_bits[0]) begin
                    mode_q <= '0;
                    srst_q <= 1'b1;
                end else begin
                    mode_q.wire4 <= wr_bits[2];
                    mode_q.lsb   <= wr_bits[1];
                end
            end
        end
    end

    always_comb begin
        unique case (sel)
            2'd0:    rd_data = {mode_q.wire4, mode_q.lsb, 1'b0, 1'b1, 4'b0000};
            2'd1:    rd_data = '0;
            2'd2:    rd_data = REV_ID;
            default: rd_data = DEV_ID;
        endcase
    end

    assign mode     = mode_q;
    assign soft_rst = srst_q;

    // R7: the reset pulse is a single cycle and leaves the defaults in place
    a_r7_pulse_once: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst);
    a_r7_defaults: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (mode == '0));
endmodule

// File: rtl/spi_rp_seq.sv
`timescale 1ns/1ps
module spi_rp_seq
    import spi_rp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  csn,
    input  logic  rise,
    input  logic  fall,
    input  logic  sdi,
    input  mode_t mode_live,
    input  byte_t rd_data,
    output logic  wr_stb,
    output logic  rd_stb,
    output addr_t acc_addr,
    output byte_t wr_data,
    output logic  dout,
    output logic  rd_phase,
    output mode_t mode_act
);
    phase_e              phase;
    logic [INSTR_W-1:0]  sh;
    logic [BCNT_W-1:0]   bitcnt;
    instr_t              ins;
    logic [LEN_W-1:0]    bdone;
    addr_t               addr;
    byte_t               osh;
    logic                dout_q;

    logic [INSTR_W-1:0]  sh_nx;
    instr_t              ins_nx;
    byte_t               byte_nx;
    addr_t               addr_adv;
    logic                instr_end, byte_end, last_byte;

    assign sh_nx     = shift_word(sh, sdi, mode_act.lsb);
    assign ins_nx    = instr_t'(sh_nx);
    assign byte_nx   = shift_byte(sh[BYTE_W-1:0], sdi, mode_act.lsb);
    assign addr_adv  = addr_next(addr, mode_act.lsb);
    assign instr_end = rise && phase == PH_INSTR && bitcnt == BCNT_W'(INSTR_W-1);
    assign byte_end  = rise && phase == PH_DATA  && bitcnt == BCNT_W'(BYTE_W-1);
    assign last_byte = (ins.len != LEN_STREAM) && (bdone == LEN_W'(ins.len));

    always_comb begin
        wr_stb   = 1'b0;
        rd_stb   = 1'b0;
        acc_addr = addr;
        if (instr_end) begin
            rd_stb   = ins_nx.rd;
            acc_addr = ins_nx.addr;
        end else if (byte_end) begin
            if (!ins.rd) begin
                wr_stb = 1'b1;
            end else if (!last_byte) begin
                rd_stb   = 1'b1;
                acc_addr = addr_adv;
            end
        end
    end

    assign wr_data  = byte_nx;
    assign dout     = dout_q;
    assign rd_phase = (phase == PH_DATA) && ins.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_INSTR;
            sh       <= '0;
            bitcnt   <= '0;
            ins      <= '0;
            bdone    <= '0;
            addr     <= '0;
            osh      <= '0;
            dout_q   <= 1'b0;
            mode_act <= '0;
        end else if (csn) begin
            phase    <= PH_INSTR;
            bitcnt   <= '0;
            dout_q   <= 1'b0;
            mode_act <= mode_live;
        end else if (rise) begin
            unique case (phase)
                PH_INSTR: begin
                    sh     <= sh_nx;
                    bitcnt <= bitcnt + 1'b1;
                    if (instr_end) begin
                        ins    <= ins_nx;
                        addr   <= ins_nx.addr;
                        bdone  <= '0;
                        bitcnt <= '0;
                        phase  <= PH_DATA;
                        if (ins_nx.rd) osh <= rd_data;
                    end
                end
                PH_DATA: begin
                    sh[BYTE_W-1:0] <= byte_nx;
                    bitcnt         <= bitcnt + 1'b1;
                    if (byte_end) begin
                        bitcnt <= '0;
                        if (last_byte) begin
                            phase <= PH_HOLD;
                        end else begin
                            addr  <= addr_adv;
                            bdone <= bdone + 1'b1;
                            if (ins.rd) osh <= rd_data;
                        end
                    end
                end
                default: ;
            endcase
        end else if (fall && phase == PH_DATA && ins.rd) begin
            dout_q <= mode_act.lsb ? osh[0] : osh[BYTE_W-1];
            osh    <= mode_act.lsb ? (osh >> 1) : (osh << 1);
        end
    end

    // R10: chip select high always returns the sequencer to the command phase
    a_r10_abort_restart: assert property (@(posedge clk) disable iff (rst)
        csn |=> (phase == PH_INSTR && bitcnt == '0));
    // R6: the working mode cannot change inside a transfer
    a_r6_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (!csn && $past(!csn)) |-> $stable(mode_act));
    // R2: once the byte count is spent, no access is issued
    a_r2_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD) |-> !(wr_stb || rd_stb));
    // R9: a single access per cycle
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && rd_stb));
endmodule

// File: rtl/spi_regport.sv
`timescale 1ns/1ps
module spi_regport
    import spi_rp_pkg::*;
#(
    parameter byte_t REV_ID = 8'hF6,
    parameter byte_t DEV_ID = 8'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic              rf_wr,
    output logic              rf_rd,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [BYTE_W-1:0] rf_wdata,
    input  logic [BYTE_W-1:0] rf_rdata,
    output logic              soft_rst_o
);
    logic  rise, fall;
    logic  wr_stb, rd_stb, dout, rd_phase, local_sel;
    addr_t acc_addr;
    byte_t wr_data, loc_rdata, rd_mux;
    mode_t mode_live, mode_act;

    spi_rp_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (spi_sclk),
        .rise (rise),
        .fall (fall)
    );

    spi_rp_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .csn       (spi_csn),
        .rise      (rise),
        .fall      (fall),
        .sdi       (sdio_in),
        .mode_live (mode_live),
        .rd_data   (rd_mux),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .acc_addr  (acc_addr),
        .wr_data   (wr_data),
        .dout      (dout),
        .rd_phase  (rd_phase),
        .mode_act  (mode_act)
    );

    spi_rp_ctrl #(.REV_ID(REV_ID), .DEV_ID(DEV_ID)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_stb & local_sel),
        .sel      (acc_addr[1:0]),
        .wr_bits  (wr_data[7:5]),
        .rd_data  (loc_rdata),
        .mode     (mode_live),
        .soft_rst (soft_rst_o)
    );

    assign local_sel = is_local(acc_addr);
    assign rd_mux    = local_sel ? loc_rdata : rf_rdata;

    assign rf_wr    = wr_stb & ~local_sel;
    assign rf_rd    = rd_stb & ~local_sel;
    assign rf_addr  = acc_addr;
    assign rf_wdata = wr_data;

    assign sdio_out = dout;
    assign sdo_out  = dout;
    assign sdio_oe  = ~spi_csn & ~mode_act.wire4 & rd_phase;
    assign sdo_oe   = ~spi_csn &  mode_act.wire4;

    // R5: never two drivers at once, and silent when deselected
    a_r5_one_driver: assert property (@(posedge clk) disable iff (rst)
        !(sdio_oe && sdo_oe));
    a_r5_idle_hiz: assert property (@(posedge clk) disable iff (rst)
        spi_csn |-> (!sdio_oe && !sdo_oe));
    // R9: local addresses never reach the downstream interface
    a_r9_local_quiet: assert property (@(posedge clk) disable iff (rst)
        (rf_wr || rf_rd) |-> (rf_addr >= ADDR_W'(LOCAL_N)));
endmodule

// File: tb/spi_regport_tb_top.sv
`timescale 1ns/1ps
module spi_regport_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, csn = 1'b1, sdio_in = 1'b0;
    logic        sdio_out, sdio_oe, sdo_out, sdo_oe, rf_wr, rf_rd, soft_rst_o;
    logic [12:0] rf_addr;
    logic [7:0]  rf_wdata, rf_rdata;

    always #2.5 clk = ~clk;

    spi_regport dut_i (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
        .rf_wr(rf_wr), .rf_rd(rf_rd), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata), .soft_rst_o(soft_rst_o)
    );

    // downstream register file model
    logic [7:0] mem [0:8191];
    assign rf_rdata = mem[rf_addr];
    int wr_cnt = 0, srst_cnt = 0;
    always @(posedge clk) begin
        if (rf_wr) begin
            mem[rf_addr] <= rf_wdata;
            wr_cnt++;
        end
        if (soft_rst_o) srst_cnt++;
    end

    int  total = 0, bad = 0;
    bit  done = 1'b0;
    bit  m_lsb = 1'b0, m_4w = 1'b0, rd_active = 1'b0;
    string cur_tag = "R1";
    logic [7:0] exp_q[$];
    logic [7:0] wbuf[8];
    logic [7:0] mon_byte = '0;
    int  mon_n = 0;
    logic mon_bit;

    function automatic logic [7:0] pat(int a);
        return 8'(a) ^ 8'h3C;
    endfunction

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // monitor: collects read bytes and compares with the scoreboard queue
    always @(posedge sclk) begin
        if (rd_active) begin
            mon_bit  = m_4w ? sdo_out : sdio_out;
            mon_byte = m_lsb ? {mon_bit, mon_byte[7:1]} : {mon_byte[6:0], mon_bit};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) chk({cur_tag, " unexpected byte"}, 16'(mon_byte), 16'hFFFF);
                else chk({cur_tag, " read data"}, 16'(mon_byte), 16'(exp_q.pop_front()));
                chk("R5 enables during read", {14'd0, sdio_oe, sdo_oe}, m_4w ? 16'd1 : 16'd2);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(logic d);
        sdio_in = d;
        tick(4);
        sclk = 1'b1;
        tick(4);
        sclk = 1'b0;
    endtask

    task automatic send_instr(logic rd, logic [1:0] len, logic [12:0] a);
        logic [15:0] w;
        w = {rd, len, a};
        for (int i = 0; i < 16; i++) sbit(m_lsb ? w[i] : w[15-i]);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 0; i < 8; i++) sbit(m_lsb ? v[i] : v[7-i]);
    endtask

    task automatic cs_lo;
        csn = 1'b0;
        tick(4);
    endtask

    task automatic cs_hi;
        tick(4);
        csn = 1'b1;
        tick(6);
    endtask

    task automatic wr_xfer(logic [1:0] len, logic [12:0] a, int n);
        cs_lo();
        send_instr(1'b0, len, a);
        for (int b = 0; b < n; b++) send_byte(wbuf[b]);
        cs_hi();
    endtask

    // driver: pushes expected bytes, then clocks the read
    task automatic rd_xfer(string tag, logic [1:0] len, logic [12:0] a, int n);
        cur_tag = tag;
        for (int b = 0; b < n; b++) exp_q.push_back(wbuf[b]);
        cs_lo();
        chk("R5 enables in command phase", {14'd0, sdio_oe, sdo_oe}, m_4w ? 16'd1 : 16'd0);
        send_instr(1'b1, len, a);
        rd_active = 1'b1;
        for (int b = 0; b < n; b++) send_byte(8'h00);
        rd_active = 1'b0;
        cs_hi();
        chk({tag, " scoreboard drained"}, 16'(exp_q.size()), 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8192; i++) mem[i] = pat(i);
        tick(5);
        rst = 1'b0;
        tick(3);

        // reset state
        chk("R5 reset sdio_oe", 16'(sdio_oe), 16'd0);
        chk("R5 reset sdo_oe", 16'(sdo_oe), 16'd0);
        chk("R7 reset pulse low", 16'(soft_rst_o), 16'd0);
        wbuf[0] = 8'h10;
        rd_xfer("R6 control default", 2'd0, 13'h0000, 1);

        // R8 identification, R3 increment, R1 MSB-first
        wbuf[0] = 8'hF6; wbuf[1] = 8'h48;
        rd_xfer("R8 id pair", 2'd1, 13'h0002, 2);

        // R2 three-byte write, R9 downstream strobes
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr_xfer(2'd2, 13'h0100, 3);
        chk("R9 write 0x100", 16'(mem[13'h100]), 16'h11);
        chk("R3 write 0x101", 16'(mem[13'h101]), 16'h22);
        chk("R2 write 0x102", 16'(mem[13'h102]), 16'h33);
        chk("R9 write strobe count", 16'(wr_cnt), 16'd3);

        // R2 streaming read across written data
        wbuf[0] = pat(16'h0FF); wbuf[1] = 8'h11; wbuf[2] = 8'h22;
        wbuf[3] = 8'h33; wbuf[4] = pat(16'h103);
        rd_xfer("R1 R2 stream read", 2'd3, 13'h00FF, 5);

        // R2 single-byte write followed by extra clocks
        wbuf[0] = 8'h77; wbuf[1] = 8'h99;
        wr_xfer(2'd0, 13'h0300, 2);
        chk("R2 single byte", 16'(mem[13'h300]), 16'h77);
        chk("R2 extra byte ignored", 16'(mem[13'h301]), 16'(pat(16'h301)));
        chk("R2 one strobe", 16'(wr_cnt), 16'd4);

        // R8 writes to fixed registers have no effect, R9 no strobe
        wbuf[0] = 8'hFF; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
        wr_xfer(2'd2, 13'h0001, 3);
        chk("R9 local write no strobe", 16'(wr_cnt), 16'd4);
        wbuf[0] = 8'h00; wbuf[1] = 8'hF6; wbuf[2] = 8'h48;
        rd_xfer("R8 fixed after write", 2'd2, 13'h0001, 3);

        // R10 abort mid-byte
        cs_lo();
        send_instr(1'b0, 2'd0, 13'h0400);
        for (int i = 0; i < 5; i++) sbit(1'b1);
        cs_hi();
        chk("R10 partial byte not written", 16'(mem[13'h400]), 16'(pat(16'h400)));
        chk("R10 no strobe", 16'(wr_cnt), 16'd4);
        wbuf[0] = 8'h48;
        rd_xfer("R10 fresh transfer", 2'd0, 13'h0003, 1);

        // R6 switch to 4-wire, LSB-first (bits 3:0 written but ignored)
        wbuf[0] = 8'hCF;
        wr_xfer(2'd0, 13'h0000, 1);
        m_lsb = 1'b1; m_4w = 1'b1;
        wbuf[0] = 8'hD0;
        rd_xfer("R6 R5 control in 4-wire", 2'd0, 13'h0000, 1);

        // R4 LSB-first write with R3 decrement
        wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C;
        wr_xfer(2'd2, 13'h0205, 3);
        chk("R4 lsb write 0x205", 16'(mem[13'h205]), 16'h5A);
        chk("R3 decrement 0x204", 16'(mem[13'h204]), 16'h6B);
        chk("R3 decrement 0x203", 16'(mem[13'h203]), 16'h7C);

        // R3 decrement through zero wraps to top
        wbuf[0] = 8'h00; wbuf[1] = 8'hD0;
        wbuf[2] = pat(16'h1FFF); wbuf[3] = pat(16'h1FFE);
        rd_xfer("R3 R4 wrap read", 2'd3, 13'h0001, 4);

        // R7 soft reset
        wbuf[0] = 8'h20;
        wr_xfer(2'd0, 13'h0000, 1);
        chk("R7 single pulse", 16'(srst_cnt), 16'd1);
        m_lsb = 1'b0; m_4w = 1'b0;
        wbuf[0] = 8'h10;
        rd_xfer("R7 control after soft reset", 2'd0, 13'h0000, 1);

        chk("R5 idle sdio_oe", 16'(sdio_oe), 16'd0);
        chk("R5 idle sdo_oe", 16'(sdo_oe), 16'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule